// File: doc/BRIEF.md
# Inter-core message send dispatcher

This block sits between the cores of a multi-core cluster and their per-core register files. A core issues a send command as a register write into a small command space. The dispatcher decodes it, resolves the 10-bit architectural ID of the target core to a physical core index, and issues the read and write requests that carry the command out on the target's register file.

Three commands exist. An interrupt send is a 32-bit write that sets one bit in the target's pending-interrupt set port. A mailbox send and an any-address send are 64-bit writes that carry a 32-bit payload. That payload goes either to one of the target's mailbox words or to any 16-bit register address of the target. A 4-bit preserve mask marks the bytes of the current target word that must survive. When the mask is not zero, the dispatcher first reads the word, then merges the payload into the other byte lanes, then writes the result. Every accepted command gets exactly one response. A target ID that no present core carries gets a decode error and causes no access.

Only one command is in flight at a time. `cmd_ready` stays low from acceptance until the command has finished.

Top module: `core_msg_dispatch`

## Requirements
- R1: The target ID is taken from command bits 25:16. It is compared against all N entries of `core_ids`, where entry k occupies bits k*10+9:k*10. The index of the lowest matching entry is driven on `rd_core` and `wr_core`.
- R2: A narrow write (`cmd_wide`=0) at offset `OFF_IRQ` is an interrupt send. It writes `SET_ADDR` of the target with the value 1 << (command bits 4:0).
- R3: If no entry matches the target ID of a recognised send, the response has `rsp_err`=1, and neither `rd_req` nor `wr_req` is asserted for that command.
- R4: A wide write at offset `OFF_MAIL` is a mailbox send. Its target address is `MBOX_BASE` + 0x20 + (command & 0x1C).
- R5: A wide write at offset `OFF_ANY` is an any-address send. Its target address is command bits 15:0.
- R6: The payload of a mailbox send or an any-address send is command bits 63:32. Command bit 27+i set keeps byte i of the word read from the target. Every other byte comes from the payload.
- R7: For a mailbox send or an any-address send with command bits 30:27 all zero, no read is issued, and the payload is written unchanged.
- R8: A command that matches none of R2, R4 and R5 is ignored. This covers a wide write at `OFF_IRQ`, a narrow write at `OFF_MAIL` or `OFF_ANY`, and any other offset. It gets a response with `rsp_err`=0 and causes no read and no write.
- R9: A masked send asserts `rd_req` for exactly one cycle. After that it waits for `rd_data_valid` and asserts `wr_req` in the cycle after the read data is taken. `cmd_ready` stays low from the cycle after acceptance until the write cycle has ended.
- R10: Each accepted command produces exactly one `rsp_valid` pulse. When the command writes, the pulse falls in the same cycle as `wr_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_ids | input | N*10 | Architectural IDs of the present cores, entry k at bits k*10+9:k*10 |
| cmd_valid | input | 1 | A send command is offered |
| cmd_ready | output | 1 | Dispatcher idle, command accepted when valid |
| cmd_wide | input | 1 | 1 for a 64-bit write, 0 for a 32-bit write |
| cmd_off | input | OFF_W | Offset of the write within the command space |
| cmd_data | input | 64 | Command word |
| rd_req | output | 1 | Read request to the target register file |
| rd_core | output | IDX_W | Target core index for the read |
| rd_addr | output | 16 | Target register address for the read |
| rd_data_valid | input | 1 | Read data returned |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Write request to the target register file |
| wr_core | output | IDX_W | Target core index for the write |
| wr_addr | output | 16 | Target register address for the write |
| wr_data | output | 32 | Write data |
| rsp_valid | output | 1 | Command completed |
| rsp_err | output | 1 | Decode error: target ID not present |

## Verification
A lookup fault shows up at the response of the same command. It appears either as a wrong `wr_core`, or as a decode error where a write was due, one cycle after acceptance for unmasked sends. A sequencer that loses track of a masked send appears at the ports as a write without a read, a second read pulse, a response that never arrives, or `cmd_ready` rising before the write. All of these are visible within the round trip of that one command. A merge fault corrupts only the kept or the replaced byte lanes of `wr_data` in the write cycle. For that reason the stimulus uses mask patterns that keep alternating lanes, all lanes and no lane, with read data that differs from the payload in every byte.

// File: rtl/core_msg_pkg.sv
package core_msg_pkg;

  localparam int CMD_W     = 64;
  localparam int PAY_LSB   = 32;
  localparam int PAY_W     = 32;
  localparam int MASK_LSB  = 27;
  localparam int MASK_W    = PAY_W / 8;
  localparam int TGT_LSB   = 16;
  localparam int TGT_W     = 10;
  localparam int VEC_W     = 5;
  localparam int SLOT_MASK = 'h1C;
  localparam int MBOX_OFS  = 'h20;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_IRQ,
    KIND_MAIL,
    KIND_ANY
  } send_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_WRITE,
    ST_RESP
  } disp_state_e;

endpackage

// File: rtl/core_id_match.sv
module core_id_match #(
  parameter int N     = 4,
  parameter int ID_W  = 10,
  parameter int IDX_W = 2
) (
  input  logic [N*ID_W-1:0] ids,
  input  logic [ID_W-1:0]   tgt,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  logic [N-1:0] eq;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign eq[g] = (ids[g*ID_W +: ID_W] == tgt);
    end
  endgenerate

  // The loop runs from the top down, so the lowest matching index is the one that remains.
  always_comb begin
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (eq[k]) idx = IDX_W'(k);
    end
    hit = |eq;
  end

  always_comb begin
    if (hit) begin
      assert_idx_matches_R1: assert (ids[idx*ID_W +: ID_W] == tgt);
    end
  end

endmodule

// File: rtl/send_decode.sv
module send_decode
  import core_msg_pkg::*;
#(
  parameter int          OFF_W     = 12,
  parameter int          ADDR_W    = 16,
  parameter logic [11:0] OFF_IRQ   = 12'h040,
  parameter logic [11:0] OFF_MAIL  = 12'h048,
  parameter logic [11:0] OFF_ANY   = 12'h158,
  parameter logic [15:0] MBOX_BASE = 16'h1000,
  parameter logic [15:0] SET_ADDR  = 16'h1008
) (
  input  logic              wide,
  input  logic [OFF_W-1:0]  off,
  input  logic [CMD_W-1:0]  cmd,
  output send_kind_e        kind,
  output logic [TGT_W-1:0]  tgt,
  output logic [ADDR_W-1:0] addr,
  output logic [PAY_W-1:0]  payload,
  output logic [MASK_W-1:0] mask
);

  logic [VEC_W-1:0]  vec;
  logic [ADDR_W-1:0] slot;

  assign vec  = cmd[VEC_W-1:0];
  assign slot = ADDR_W'(cmd[7:0] & 8'(SLOT_MASK));
  assign tgt  = cmd[TGT_LSB +: TGT_W];

  always_comb begin
    kind    = KIND_NONE;
    addr    = '0;
    payload = '0;
    mask    = '0;
    if (!wide && off == OFF_W'(OFF_IRQ)) begin
      kind    = KIND_IRQ;
      addr    = ADDR_W'(SET_ADDR);
      payload = PAY_W'(1) << vec;
    end else if (wide && off == OFF_W'(OFF_MAIL)) begin
      kind    = KIND_MAIL;
      addr    = ADDR_W'(MBOX_BASE) + ADDR_W'(MBOX_OFS) + slot;
      payload = cmd[PAY_LSB +: PAY_W];
      mask    = cmd[MASK_LSB +: MASK_W];
    end else if (wide && off == OFF_W'(OFF_ANY)) begin
      kind    = KIND_ANY;
      addr    = cmd[ADDR_W-1:0];
      payload = cmd[PAY_LSB +: PAY_W];
      mask    = cmd[MASK_LSB +: MASK_W];
    end
  end

endmodule

// File: rtl/byte_keep_merge.sv
module byte_keep_merge #(
  parameter int BYTES = 4
) (
  input  logic [BYTES*8-1:0] cur,
  input  logic [BYTES*8-1:0] pay,
  input  logic [BYTES-1:0]   keep,
  output logic [BYTES*8-1:0] merged
);

  genvar b;
  generate
    for (b = 0; b < BYTES; b++) begin : g_lane
      assign merged[b*8 +: 8] = keep[b] ? cur[b*8 +: 8] : pay[b*8 +: 8];
    end
  endgenerate

endmodule

// File: rtl/core_msg_dispatch.sv
module core_msg_dispatch
  import core_msg_pkg::*;
#(
  parameter int          N         = 4,
  parameter int          OFF_W     = 12,
  parameter int          ADDR_W    = 16,
  parameter logic [11:0] OFF_IRQ   = 12'h040,
  parameter logic [11:0] OFF_MAIL  = 12'h048,
  parameter logic [11:0] OFF_ANY   = 12'h158,
  parameter logic [15:0] MBOX_BASE = 16'h1000,
  parameter logic [15:0] SET_ADDR  = 16'h1008,
  localparam int         IDX_W     = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N*TGT_W-1:0]  core_ids,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_wide,
  input  logic [OFF_W-1:0]    cmd_off,
  input  logic [CMD_W-1:0]    cmd_data,
  output logic                rd_req,
  output logic [IDX_W-1:0]    rd_core,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic                rd_data_valid,
  input  logic [PAY_W-1:0]    rd_data,
  output logic                wr_req,
  output logic [IDX_W-1:0]    wr_core,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [PAY_W-1:0]    wr_data,
  output logic                rsp_valid,
  output logic                rsp_err
);

  // decode and lookup
  send_kind_e        dec_kind;
  logic [TGT_W-1:0]  dec_tgt;
  logic [ADDR_W-1:0] dec_addr;
  logic [PAY_W-1:0]  dec_pay;
  logic [MASK_W-1:0] dec_mask;
  logic              id_hit;
  logic [IDX_W-1:0]  id_idx;

  send_decode #(
    .OFF_W(OFF_W), .ADDR_W(ADDR_W), .OFF_IRQ(OFF_IRQ), .OFF_MAIL(OFF_MAIL),
    .OFF_ANY(OFF_ANY), .MBOX_BASE(MBOX_BASE), .SET_ADDR(SET_ADDR)
  ) u_dec (
    .wide(cmd_wide), .off(cmd_off), .cmd(cmd_data), .kind(dec_kind),
    .tgt(dec_tgt), .addr(dec_addr), .payload(dec_pay), .mask(dec_mask)
  );

  core_id_match #(.N(N), .ID_W(TGT_W), .IDX_W(IDX_W)) u_match (
    .ids(core_ids), .tgt(dec_tgt), .hit(id_hit), .idx(id_idx)
  );

  // state
  disp_state_e       state_q, state_d;
  send_kind_e        kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PAY_W-1:0]  data_q, data_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic [IDX_W-1:0]  core_q, core_d;
  logic              err_q, err_d;
  logic              accept, capture, load_en;
  logic [PAY_W-1:0]  merged;

  byte_keep_merge #(.BYTES(MASK_W)) u_merge (
    .cur(rd_data), .pay(data_q), .keep(mask_q), .merged(merged)
  );

  assign accept  = (state_q == ST_IDLE) && cmd_valid;
  assign capture = (state_q == ST_WAIT) && rd_data_valid;
  assign load_en = accept || capture;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    addr_d  = addr_q;
    data_d  = data_q;
    mask_d  = mask_q;
    core_d  = core_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          kind_d = dec_kind;
          addr_d = dec_addr;
          data_d = dec_pay;
          mask_d = dec_mask;
          core_d = id_idx;
          err_d  = (dec_kind != KIND_NONE) && !id_hit;
          if (dec_kind == KIND_NONE || !id_hit) state_d = ST_RESP;
          else if (dec_mask != '0)               state_d = ST_READ;
          else                                   state_d = ST_WRITE;
        end
      end
      ST_READ:  state_d = ST_WAIT;
      ST_WAIT: begin
        if (rd_data_valid) begin
          data_d  = merged;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: state_d = ST_IDLE;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= KIND_NONE;
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
      core_q <= '0;
      err_q  <= 1'b0;
    end else if (load_en) begin
      kind_q <= kind_d;
      addr_q <= addr_d;
      data_q <= data_d;
      mask_q <= mask_d;
      core_q <= core_d;
      err_q  <= err_d;
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign rd_req    = (state_q == ST_READ);
  assign rd_core   = core_q;
  assign rd_addr   = addr_q;
  assign wr_req    = (state_q == ST_WRITE);
  assign wr_core   = core_q;
  assign wr_addr   = addr_q;
  assign wr_data   = data_q;
  assign rsp_valid = (state_q == ST_WRITE) || (state_q == ST_RESP);
  assign rsp_err   = rsp_valid && err_q;

  // checks
  assert_err_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !wr_req && !rd_req);

  assert_irq_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && kind_q == KIND_IRQ) |-> $onehot(wr_data));

  assert_read_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req && !cmd_ready && !wr_req);

  assert_read_only_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (mask_q != '0));

  assert_write_has_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> rsp_valid && !cmd_ready);

  assert_rsp_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_ignored_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && kind_q == KIND_NONE) |-> !wr_req && !rsp_err);

endmodule

// File: tb/tb_core_msg_dispatch.sv
module tb_core_msg_dispatch;

  localparam int N = 4;
  localparam logic [11:0] OFF_IRQ  = 12'h040;
  localparam logic [11:0] OFF_MAIL = 12'h048;
  localparam logic [11:0] OFF_ANY  = 12'h158;
  localparam logic [15:0] MBOX_BASE = 16'h1000;
  localparam logic [15:0] SET_ADDR  = 16'h1008;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N*10-1:0] core_ids;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_wide = 1'b0;
  logic [11:0] cmd_off = '0;
  logic [63:0] cmd_data = '0;
  logic        rd_req;
  logic [1:0]  rd_core;
  logic [15:0] rd_addr;
  logic        rd_data_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        wr_req;
  logic [1:0]  wr_core;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic        rsp_valid;
  logic        rsp_err;

  always #4 clk = ~clk;

  core_msg_dispatch #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .core_ids(core_ids),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_wide(cmd_wide),
    .cmd_off(cmd_off), .cmd_data(cmd_data),
    .rd_req(rd_req), .rd_core(rd_core), .rd_addr(rd_addr),
    .rd_data_valid(rd_data_valid), .rd_data(rd_data),
    .wr_req(wr_req), .wr_core(wr_core), .wr_addr(wr_addr), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err)
  );

  typedef struct {
    string       req;
    bit          err;
    bit          wr;
    bit          rd;
    logic [15:0] addr;
    logic [31:0] data;
    logic [1:0]  core;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  logic [9:0] ids [N];
  int   rd_delay = 0;
  bit   rd_seen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mem_val(input logic [1:0] c, input logic [15:0] a);
    return 32'hC3D4E5F6 ^ {6'b0, c, 8'h00, a};
  endfunction

  function automatic int find_idx(input logic [9:0] id);
    for (int k = 0; k < N; k++) if (ids[k] == id) return k;
    return -1;
  endfunction

  function automatic logic [31:0] keep_merge(input logic [31:0] cur, input logic [31:0] pay,
                                             input logic [3:0] m);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = m[b] ? cur[b*8 +: 8] : pay[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [63:0] mk(input logic [31:0] pay, input logic [3:0] m,
                                     input logic [9:0] id, input logic [15:0] lo);
    return {pay, 1'b0, m, 1'b0, id, lo};
  endfunction

  task automatic apply_ids();
    for (int k = 0; k < N; k++) core_ids[k*10 +: 10] = ids[k];
  endtask

  task automatic drive(input bit wide, input logic [11:0] off, input logic [63:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_wide  = wide;
    cmd_off   = off;
    cmd_data  = d;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // builds the expectation from the requirements and sends the command
  task automatic send(input string req, input bit wide, input logic [11:0] off,
                      input logic [63:0] d);
    exp_t e;
    int   idx;
    logic [3:0] m;
    logic [31:0] pay;
    e.req = req; e.err = 0; e.wr = 0; e.rd = 0; e.addr = '0; e.data = '0; e.core = '0;
    idx = find_idx(d[25:16]);
    m   = d[30:27];
    pay = d[63:32];
    if (!wide && off == OFF_IRQ) begin
      if (idx < 0) e.err = 1;
      else begin
        e.wr = 1; e.core = 2'(idx); e.addr = SET_ADDR;
        e.data = 32'h1 << d[4:0];
      end
    end else if (wide && (off == OFF_MAIL || off == OFF_ANY)) begin
      if (idx < 0) e.err = 1;
      else begin
        e.wr = 1; e.core = 2'(idx);
        e.addr = (off == OFF_MAIL) ? MBOX_BASE + 16'h20 + {8'h0, d[7:0] & 8'h1C} : d[15:0];
        e.rd = (m != 4'h0);
        e.data = e.rd ? keep_merge(mem_val(e.core, e.addr), pay, m) : pay;
      end
    end
    exp_q.push_back(e);
    drive(wide, off, d);
  endtask

  // read responder
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        logic [31:0] v;
        v = mem_val(rd_core, rd_addr);
        repeat (rd_delay) @(negedge clk);
        rd_delay = (rd_delay + 1) % 3;
        @(negedge clk);
        rd_data = v;
        rd_data_valid = 1'b1;
        @(negedge clk);
        rd_data_valid = 1'b0;
        rd_data = '0;
      end
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        if (exp_q.size() == 0) chk(0, "R9", "read with nothing pending", 32'(rd_req), 32'h0);
        else begin
          chk(exp_q[0].rd, exp_q[0].rd ? "R6" : "R7", "read issued", 32'h1, 32'(exp_q[0].rd));
          chk(rd_addr == exp_q[0].addr, "R9", "read addr", 32'(rd_addr), 32'(exp_q[0].addr));
          chk(rd_core == exp_q[0].core, "R1", "read core", 32'(rd_core), 32'(exp_q[0].core));
          chk(!cmd_ready, "R9", "ready during read", 32'(cmd_ready), 32'h0);
        end
        rd_seen = 1;
      end
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(0, "R10", "response with nothing pending", 32'h1, 32'h0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rsp_err == e.err, e.err ? "R3" : e.req, "rsp_err", 32'(rsp_err), 32'(e.err));
          chk(wr_req == e.wr, e.wr ? "R10" : (e.err ? "R3" : "R8"), "wr_req",
              32'(wr_req), 32'(e.wr));
          chk(rd_seen == e.rd, e.rd ? "R9" : "R7", "read seen", 32'(rd_seen), 32'(e.rd));
          if (e.wr && wr_req) begin
            chk(wr_core == e.core, "R1", "wr_core", 32'(wr_core), 32'(e.core));
            chk(wr_addr == e.addr, e.req, "wr_addr", 32'(wr_addr), 32'(e.addr));
            chk(wr_data == e.data, e.req, "wr_data", wr_data, e.data);
          end
        end
        rd_seen = 0;
      end else if (wr_req) begin
        chk(0, "R10", "write without response", 32'h1, 32'h0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    ids[0] = 10'h005; ids[1] = 10'h120; ids[2] = 10'h3FF; ids[3] = 10'h042;
    apply_ids();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9", "reset ready", 32'(cmd_ready), 32'h1);
    chk(!wr_req && !rd_req && !rsp_valid, "R10", "reset idle outputs",
        {29'h0, wr_req, rd_req, rsp_valid}, 32'h0);

    send("R2", 0, OFF_IRQ, 64'h0000_0000_0120_0000);                   // vector 0 to core 1
    send("R2", 0, OFF_IRQ, 64'hFFFF_FFFF_0042_001F);                   // vector 31 to core 3
    send("R3", 0, OFF_IRQ, 64'h0000_0000_0200_0003);                   // absent ID
    send("R4", 1, OFF_MAIL, mk(32'h1122_3344, 4'h0, 10'h005, 16'h000C));
    send("R4", 1, OFF_MAIL, mk(32'hA1B2_C3D4, 4'h0, 10'h3FF, 16'hFFFF)); // slot bits from 0x1C only
    send("R6", 1, OFF_MAIL, mk(32'h5566_7788, 4'b0101, 10'h3FF, 16'h0010));
    send("R6", 1, OFF_MAIL, mk(32'h99AA_BBCC, 4'b1111, 10'h120, 16'h0004));
    send("R5", 1, OFF_ANY, mk(32'hDEAD_BEEF, 4'h0, 10'h042, 16'h1234));
    send("R6", 1, OFF_ANY, mk(32'h0F0E_0D0C, 4'b1010, 10'h005, 16'h0ABC));
    send("R6", 1, OFF_ANY, mk(32'h7777_7777, 4'b1000, 10'h042, 16'hF000));
    send("R3", 1, OFF_ANY, mk(32'h1234_5678, 4'b0011, 10'h201, 16'h0100)); // no read on miss
    send("R3", 1, OFF_MAIL, mk(32'h1234_5678, 4'h0, 10'h000, 16'h0000));
    send("R8", 0, OFF_MAIL, mk(32'h1111_1111, 4'h0, 10'h005, 16'h0000));
    send("R8", 0, OFF_ANY, mk(32'h2222_2222, 4'b0001, 10'h005, 16'h0000));
    send("R8", 1, OFF_IRQ, mk(32'h3333_3333, 4'h0, 10'h005, 16'h0001));
    send("R8", 1, 12'h050, mk(32'h4444_4444, 4'h0, 10'h005, 16'h0000));
    send("R7", 1, OFF_ANY, mk(32'hCAFE_F00D, 4'h0, 10'h3FF, 16'h00A0));

    // duplicate ID: lowest index wins
    @(negedge clk);
    while (exp_q.size() != 0) @(negedge clk);
    ids[2] = 10'h120;
    apply_ids();
    send("R1", 0, OFF_IRQ, 64'h0000_0000_0120_0007);
    send("R1", 1, OFF_ANY, mk(32'h0102_0304, 4'b0110, 10'h120, 16'h0044));

    @(negedge clk);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(cmd_ready && !rsp_valid, "R10", "idle after run", {30'h0, cmd_ready, rsp_valid}, 32'h2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule